// File: doc/BRIEF.md
# SPI NOR flash programming sequencer

This block is a hardware SPI master that writes a region of a serial NOR flash without software stepping through the commands. A control port gives it a start offset, a byte count, an erase granularity and two poll settings. A single-cycle `start` pulse loads these values. The block then runs the whole session by itself. It wakes the flash and erases every block the region touches. It writes the data bytes that arrive on a valid/ready byte stream, puts the flash back to sleep and pulses `done`.

Each erase and each program command is preceded by its own write-enable frame. After each of those commands the block polls the status byte until the flash has reported ready on three polls in a row. Program bursts stop at 256-byte page boundaries. If a poll sequence does not finish within the configured number of polls, the block sets an error flag, skips the rest of the work and closes the session with the sleep command.

Top module: `spi_nor_prog_seq`

## Requirements
- R1: While reset is held and right after it is released, `cs_n` is 1, `sck` is 0, and `done`, `err` and `in_ready` are 0.
- R2: Every session opens with a frame of eight 0xFF bytes, followed by a one-byte frame holding 0xAB.
- R3: Every erase frame and every program frame comes directly after its own one-byte frame holding 0x06.
- R4: `gran` selects the erase command. 2'b00 sends 0x20 (4 KB blocks), 2'b01 sends 0x52 (32 KB), 2'b10 sends 0xD8 (64 KB), and 2'b11 sends a one-byte 0xC7 frame that erases the whole chip.
- R5: For block erase, the region runs from `offset` rounded down to the block size up to `offset+length` rounded up to the block size. One erase is issued per block, in ascending address order.
- R6: Erase and program frames carry the opcode byte followed by a 24-bit address, high byte first.
- R7: Program frames use opcode 0x02. Each carries min(256 - address mod 256, bytes remaining) data bytes, taken from the stream in arrival order. A session takes exactly `length` bytes from the stream.
- R8: A status poll is a two-byte frame: 0x05, then one byte read from `miso` in which bit 0 set means busy. Polling ends after three ready readings in a row, and any busy reading restarts that run.
- R9: Every session ends with a one-byte 0xB9 frame. `done` is then high for exactly one cycle, and no further frame follows.
- R10: SPI mode 0 is used. `sck` is low whenever `cs_n` is high, `mosi` changes only while `sck` is low, and `miso` is sampled on the rising `sck` edge.
- R11: Between frames, `cs_n` stays high for at least 4*CLK_HALF clock cycles (two SCK periods). Between two consecutive status polls it stays high for at least `poll_gap` cycles.
- R12: If `poll_limit` polls of one operation pass without completion, `err` is set, no further stream byte is accepted, and the session closes with 0xB9 and `done`. `err` stays set until the next `start`.
- R13: With block granularity, a zero `length` and a block-aligned `offset`, the session sends only the wake, 0xAB and 0xB9 frames and takes no stream bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a session when idle; the settings are sampled on this cycle |
| offset | input | 24 | First flash byte address to write |
| length | input | LEN_W | Number of bytes to write |
| gran | input | 2 | Erase granularity select (see R4) |
| poll_gap | input | GAP_W | Extra idle cycles between two status polls |
| poll_limit | input | CNT_W | Maximum polls per operation before the error exit |
| in_data | input | 8 | Stream data byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Sequencer takes the stream byte this cycle |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |
| cs_n | output | 1 | Flash chip select, active low |
| done | output | 1 | One-cycle pulse at the end of a session |
| err | output | 1 | Poll timeout flag, cleared by `start` |

## Verification
A wrong frame counter or a wrong kind register shows up on the SPI pins within the same frame. It appears as a wrong byte count, a wrong opcode or a missing write-enable frame, and the bench frame decoder catches it when `cs_n` next rises. Faulty erase or page arithmetic shows up in the address field of the first affected frame, or in a program payload byte that does not match the stream index of that address. A wrong ready-run count or a wrong busy mask changes how many 0x05 frames appear between an operation and the next write-enable. The bench sets the flash model's busy pattern, so that count is known, including a busy reading placed after two ready ones.

// File: rtl/spi_nor_seq_pkg.sv
package spi_nor_seq_pkg;

  typedef enum logic [2:0] {
    K_WAKE, K_RPD, K_WREN, K_ERASE, K_CHIP, K_PROG, K_POLL, K_SLEEP
  } xfer_kind_t;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_LOAD, S_SHIFT} seq_state_t;

  localparam logic [1:0] GR_CHIP = 2'b11;

  // Opcode for the selected erase granularity.
  function automatic logic [7:0] erase_opcode(logic [1:0] g);
    case (g)
      2'b00:   return 8'h20;
      2'b01:   return 8'h52;
      2'b10:   return 8'hD8;
      default: return 8'hC7;
    endcase
  endfunction

  // log2 of the erase block size in bytes.
  function automatic int unsigned gran_shift(logic [1:0] g);
    case (g)
      2'b00:   return 12;
      2'b01:   return 15;
      default: return 16;
    endcase
  endfunction

  function automatic logic [25:0] align_down(logic [25:0] a, int unsigned sh);
    return (a >> sh) << sh;
  endfunction

  function automatic logic [25:0] align_up(logic [25:0] a, int unsigned sh);
    logic [25:0] m;
    m = (26'd1 << sh) - 26'd1;
    return (a + m) & ~m;
  endfunction

  // Bytes for one program burst: never past the end of the page.
  function automatic logic [8:0] burst_len(logic [23:0] a, logic [31:0] r);
    logic [8:0] room;
    room = 9'd256 - {1'b0, a[7:0]};
    return (r < {23'd0, room}) ? r[8:0] : room;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       fin
);
  localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic          active;
  logic [2:0]    bitn;
  logic [DW-1:0] div;
  logic [7:0]    sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      bitn   <= '0;
      div    <= '0;
      sh     <= '0;
      rx     <= '0;
      sck    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        sh     <= tx;
        bitn   <= '0;
        div    <= '0;
      end else if (active) begin
        if (div == DW'(CLK_HALF - 1)) begin
          div <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              fin    <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end

  a_r10_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r10_sck_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $past(active));

endmodule

// File: rtl/poll_streak_tracker.sv
module poll_streak_tracker #(
  parameter int         RUN       = 3,
  parameter int         CNT_W     = 16,
  parameter logic [7:0] BUSY_MASK = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic [7:0]       status,
  input  logic [CNT_W-1:0] limit,
  output logic             finish,
  output logic             expire
);
  localparam int SW = $clog2(RUN + 1);

  logic [SW-1:0]    streak;
  logic [CNT_W-1:0] polls;
  logic             busy_bit;

  assign busy_bit = |(status & BUSY_MASK);
  assign finish   = sample && !busy_bit && (streak == SW'(RUN - 1));
  assign expire   = sample && !finish &&
                    (({1'b0, polls} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak <= '0;
      polls  <= '0;
    end else if (clr) begin
      streak <= '0;
      polls  <= '0;
    end else if (sample) begin
      polls  <= polls + CNT_W'(1);
      streak <= busy_bit ? '0 : streak + SW'(1);
    end
  end

  a_r8_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (streak < SW'(RUN)));

endmodule

// File: rtl/spi_nor_prog_seq.sv
module spi_nor_prog_seq import spi_nor_seq_pkg::*; #(
  parameter int CLK_HALF  = 2,
  parameter int LEN_W     = 24,
  parameter int GAP_W     = 16,
  parameter int CNT_W     = 16,
  parameter int READY_RUN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      offset,
  input  logic [LEN_W-1:0] length,
  input  logic [1:0]       gran,
  input  logic [GAP_W-1:0] poll_gap,
  input  logic [CNT_W-1:0] poll_limit,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             done,
  output logic             err
);
  localparam int GAP_MIN = 4 * CLK_HALF;
  localparam int GC_W    = GAP_W + $clog2(GAP_MIN + 1) + 1;

  seq_state_t       state;
  xfer_kind_t       kind, pend;
  logic [8:0]       idx, last_idx, burst;
  logic [GC_W-1:0]  gap_cnt, gap_len;
  logic [25:0]      eaddr, ehi, blk;
  logic [23:0]      paddr;
  logic [LEN_W-1:0] rem;
  logic [1:0]       gran_r;
  logic [GAP_W-1:0] pgap_r;
  logic [CNT_W-1:0] plim_r;
  logic [7:0]       cmd_byte, eng_tx, eng_rx;
  logic             need_data, eng_go, eng_fin;
  logic             frame_end, op_end, poll_sample, pt_finish, pt_expire;
  logic             cs_q, done_q, err_q, erase_more;

  assign cs_n = cs_q;
  assign done = done_q;
  assign err  = err_q;

  always_comb begin
    blk        = 26'd1 << gran_shift(gran_r);
    burst      = burst_len(paddr, 32'(rem));
    erase_more = (eaddr + blk) < ehi;
    last_idx   = 9'd0;
    case (kind)
      K_WAKE:  last_idx = 9'd7;
      K_ERASE: last_idx = 9'd3;
      K_PROG:  last_idx = 9'd3 + burst;
      K_POLL:  last_idx = 9'd1;
      default: last_idx = 9'd0;
    endcase
    cmd_byte = 8'h00;
    case (kind)
      K_WAKE:  cmd_byte = 8'hFF;
      K_RPD:   cmd_byte = 8'hAB;
      K_WREN:  cmd_byte = 8'h06;
      K_CHIP:  cmd_byte = 8'hC7;
      K_SLEEP: cmd_byte = 8'hB9;
      K_POLL:  cmd_byte = (idx == 9'd0) ? 8'h05 : 8'h00;
      K_ERASE, K_PROG: begin
        case (idx)
          9'd0:    cmd_byte = (kind == K_PROG) ? 8'h02 : erase_opcode(gran_r);
          9'd1:    cmd_byte = (kind == K_PROG) ? paddr[23:16] : eaddr[23:16];
          9'd2:    cmd_byte = (kind == K_PROG) ? paddr[15:8]  : eaddr[15:8];
          default: cmd_byte = (kind == K_PROG) ? paddr[7:0]   : eaddr[7:0];
        endcase
      end
      default: cmd_byte = 8'h00;
    endcase
  end

  assign need_data   = (kind == K_PROG) && (idx >= 9'd4);
  assign in_ready    = (state == S_LOAD) && need_data;
  assign eng_go      = (state == S_LOAD) && (!need_data || in_valid);
  assign eng_tx      = need_data ? in_data : cmd_byte;
  assign frame_end   = (state == S_SHIFT) && eng_fin && (idx == last_idx);
  assign op_end      = frame_end && ((kind == K_ERASE) || (kind == K_CHIP) || (kind == K_PROG));
  assign poll_sample = frame_end && (kind == K_POLL);

  spi_byte_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .miso(miso),
    .sck(sck), .mosi(mosi), .rx(eng_rx), .fin(eng_fin)
  );

  poll_streak_tracker #(.RUN(READY_RUN), .CNT_W(CNT_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(op_end), .sample(poll_sample),
    .status(eng_rx), .limit(plim_r), .finish(pt_finish), .expire(pt_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind    <= K_WAKE;
      pend    <= K_WAKE;
      idx     <= '0;
      gap_cnt <= '0;
      gap_len <= '0;
      eaddr   <= '0;
      ehi     <= '0;
      paddr   <= '0;
      rem     <= '0;
      gran_r  <= '0;
      pgap_r  <= '0;
      plim_r  <= '0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          eaddr   <= align_down({2'b00, offset}, gran_shift(gran));
          ehi     <= align_up(26'(offset) + 26'(length), gran_shift(gran));
          paddr   <= offset;
          rem     <= length;
          gran_r  <= gran;
          pgap_r  <= poll_gap;
          plim_r  <= poll_limit;
          err_q   <= 1'b0;
          kind    <= K_WAKE;
          gap_cnt <= '0;
          gap_len <= GC_W'(GAP_MIN);
          state   <= S_GAP;
        end
        S_GAP: begin
          if (gap_cnt == gap_len) begin
            cs_q  <= 1'b0;
            idx   <= '0;
            state <= S_LOAD;
          end else begin
            gap_cnt <= gap_cnt + GC_W'(1);
          end
        end
        S_LOAD: if (eng_go) state <= S_SHIFT;
        S_SHIFT: if (eng_fin) begin
          if (idx != last_idx) begin
            idx   <= idx + 9'd1;
            state <= S_LOAD;
          end else begin
            cs_q    <= 1'b1;
            gap_cnt <= '0;
            gap_len <= GC_W'(GAP_MIN);
            state   <= S_GAP;
            case (kind)
              K_WAKE: kind <= K_RPD;
              K_RPD: begin
                if (gran_r == GR_CHIP) begin
                  kind <= K_WREN; pend <= K_CHIP;
                end else if (eaddr < ehi) begin
                  kind <= K_WREN; pend <= K_ERASE;
                end else if (rem != '0) begin
                  kind <= K_WREN; pend <= K_PROG;
                end else begin
                  kind <= K_SLEEP;
                end
              end
              K_WREN: kind <= pend;
              K_ERASE, K_CHIP, K_PROG: kind <= K_POLL;
              K_POLL: begin
                if (pt_finish) begin
                  if (pend == K_ERASE) begin
                    eaddr <= eaddr + blk;
                    if (erase_more) begin
                      kind <= K_WREN; pend <= K_ERASE;
                    end else if (rem != '0) begin
                      kind <= K_WREN; pend <= K_PROG;
                    end else begin
                      kind <= K_SLEEP;
                    end
                  end else if (pend == K_CHIP) begin
                    if (rem != '0) begin
                      kind <= K_WREN; pend <= K_PROG;
                    end else begin
                      kind <= K_SLEEP;
                    end
                  end else begin
                    paddr <= paddr + 24'(burst);
                    rem   <= rem - LEN_W'(burst);
                    if (rem != LEN_W'(burst)) begin
                      kind <= K_WREN; pend <= K_PROG;
                    end else begin
                      kind <= K_SLEEP;
                    end
                  end
                end else if (pt_expire) begin
                  err_q <= 1'b1;
                  kind  <= K_SLEEP;
                end else begin
                  gap_len <= GC_W'(GAP_MIN) + GC_W'(pgap_r);
                end
              end
              K_SLEEP: begin
                done_q <= 1'b1;
                state  <= S_IDLE;
              end
              default: kind <= K_SLEEP;
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r11_cs_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_data_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cs_n);

  a_r12_no_data_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready);

endmodule

// File: tb/spi_nor_prog_seq_test.sv
module spi_nor_prog_seq_test;
  localparam int HALF = 1;
  localparam int LW   = 24;
  localparam int MAXF = 2048;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] offset = '0;
  logic [LW-1:0] length = '0;
  logic [1:0] gran = '0;
  logic [15:0] poll_gap = '0, poll_limit = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, miso = 1'b0;
  logic in_ready, sck, mosi, cs_n, done, err;

  always #5 clk = ~clk;

  spi_nor_prog_seq #(.CLK_HALF(HALF), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .length(length),
    .gran(gran), .poll_gap(poll_gap), .poll_limit(poll_limit), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .sck(sck), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .done(done), .err(err)
  );

  int checks = 0, errors = 0;
  int sidx = 0, cur_off = 0, cfg_busy_n = 0, fp = 0, nfr = 0, mode_bad = 0;
  bit cfg_flick = 0, stream_en = 0;
  int f_op[MAXF], f_addr[MAXF], f_n[MAXF], f_gap[MAXF];
  bit f_dok[MAXF];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'(k * 37 + (k >> 8) * 11 + 90);
  endfunction

  function automatic bit poll_busy(int p);
    if (p < cfg_busy_n) return 1'b1;
    if (cfg_flick) return (p - cfg_busy_n) == 2;
    return 1'b0;
  endfunction

  // Stream source: handshake seen mid-cycle, new data after the edge.
  initial begin
    void'($urandom(32'd4242));
    forever begin
      bit fire;
      @(negedge clk);
      fire = in_valid && in_ready;
      @(posedge clk);
      #1;
      if (fire) sidx++;
      in_valid = stream_en && ($urandom % 4 != 0);
      in_data  = pat(sidx);
    end
  end

  // Flash model and frame decoder.
  initial begin
    bit psck = 0, pcs = 1, pmosi = 0, busy_now = 0;
    int bi = 0, bt = 0, hi_cnt = 0, pidx = 0;
    logic [7:0] sh = '0, outb;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pcs && !cs_n) begin
          if (nfr < MAXF) begin
            f_gap[nfr] = hi_cnt; f_dok[nfr] = 1; f_op[nfr] = -1; f_addr[nfr] = 0;
          end
          bi = 0; bt = 0; busy_now = poll_busy(pidx);
        end
        if (!cs_n && sck && !psck && nfr < MAXF) begin
          sh = {sh[6:0], mosi};
          bt++;
          if (bt == 8) begin
            if (bi == 0) f_op[nfr] = sh;
            else if ((f_op[nfr] == 'h20 || f_op[nfr] == 'h52 || f_op[nfr] == 'hD8 ||
                      f_op[nfr] == 'h02) && bi <= 3)
              f_addr[nfr] = (f_addr[nfr] << 8) | sh;
            else if (f_op[nfr] == 'h02 && sh != pat((f_addr[nfr] + bi - 4 - cur_off) & 'hFFFFFF))
              f_dok[nfr] = 0;
            if (f_op[nfr] == 'hFF && sh != 8'hFF) f_dok[nfr] = 0;
            bi++; bt = 0;
          end
        end
        if (sck && psck && mosi != pmosi) mode_bad++;
        if (cs_n && sck) mode_bad++;
        if (!pcs && cs_n && nfr < MAXF) begin
          f_n[nfr] = bi;
          if (f_op[nfr] == 'h20 || f_op[nfr] == 'h52 || f_op[nfr] == 'hD8 ||
              f_op[nfr] == 'hC7 || f_op[nfr] == 'h02) pidx = 0;
          else if (f_op[nfr] == 'h05) pidx++;
          nfr++; hi_cnt = 0;
        end
        if (cs_n) hi_cnt++;
      end
      outb = (!cs_n && bi == 1 && nfr < MAXF && f_op[nfr] == 'h05) ? {7'b1010010, busy_now} : 8'h00;
      miso = outb[3'(7 - bt)];
      psck = sck; pcs = cs_n; pmosi = mosi;
    end
  end

  task automatic exp_frame(input string req, input int op, input int addr,
                           input int n, input bit use_addr);
    chk(fp < nfr, req, "frame present", nfr, fp + 1);
    chk(f_op[fp] == op, req, "opcode", f_op[fp], op);
    chk(f_n[fp] == n, req, "frame bytes", f_n[fp], n);
    if (use_addr) chk(f_addr[fp] == addr, "R6", "address", f_addr[fp], addr);
    chk(f_dok[fp], req, "payload", 0, 1);
    if (fp > 0) chk(f_gap[fp] >= 4 * HALF, "R11", "deselect time", f_gap[fp], 4 * HALF);
    fp++;
  endtask

  task automatic exp_polls(input int want, input int pg);
    int cnt = 0;
    bit shape_ok = 1, gap_ok = 1;
    while (fp < nfr && f_op[fp] == 'h05) begin
      if (f_n[fp] != 2) shape_ok = 0;
      if (cnt > 0 && f_gap[fp] < pg) gap_ok = 0;
      cnt++; fp++;
    end
    chk(cnt == want, "R8", "poll count", cnt, want);
    chk(shape_ok, "R8", "poll frame shape", 0, 1);
    chk(gap_ok, "R11", "poll spacing", 0, pg);
  endtask

  task automatic run_case(input int off, input int len, input int g, input int bn,
                          input bit fl, input int pg, input int pl, input bit to);
    int blk, lo, hi, a, r, n, eop, wantp;
    @(negedge clk);
    offset = 24'(off); length = LW'(len); gran = 2'(g);
    poll_gap = 16'(pg); poll_limit = 16'(pl);
    cur_off = off; cfg_busy_n = bn; cfg_flick = fl;
    nfr = 0; fp = 0; sidx = 0; stream_en = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0, "R12", "err cleared by start", err, 0);
    while (!done) @(negedge clk);
    chk(err == to, "R12", "err at done", err, to);
    stream_en = 0;
    repeat (6) @(negedge clk);
    chk(done == 1'b0, "R9", "done width", done, 0);
    chk(err == to, "R12", "err held", err, to);
    chk(cs_n && !sck, "R10", "idle pins", {cs_n, sck}, 2'b10);
    chk(sidx == (to ? 0 : len), "R7", "stream bytes taken", sidx, to ? 0 : len);
    wantp = bn + 3 + (fl ? 3 : 0);
    exp_frame("R2", 'hFF, 0, 8, 0);
    exp_frame("R2", 'hAB, 0, 1, 0);
    if (g == 3) begin
      exp_frame("R3", 'h06, 0, 1, 0);
      exp_frame("R4", 'hC7, 0, 1, 0);
      exp_polls(to ? pl : wantp, pg);
    end else begin
      blk = (g == 0) ? 4096 : (g == 1) ? 32768 : 65536;
      eop = (g == 0) ? 'h20 : (g == 1) ? 'h52 : 'hD8;
      lo = off - (off % blk);
      hi = ((off + len + blk - 1) / blk) * blk;
      for (int e = lo; e < hi; e += blk) begin
        exp_frame("R3", 'h06, 0, 1, 0);
        exp_frame("R5", eop, e, 4, 1);
        exp_polls(to ? pl : wantp, pg);
        if (to) break;
      end
    end
    if (!to) begin
      a = off; r = len;
      while (r > 0) begin
        n = 256 - (a % 256);
        if (r < n) n = r;
        exp_frame("R3", 'h06, 0, 1, 0);
        exp_frame("R7", 'h02, a, 4 + n, 1);
        exp_polls(wantp, pg);
        a = (a + n) & 'hFFFFFF; r -= n;
      end
    end
    exp_frame("R9", 'hB9, 0, 1, 0);
    chk(fp == nfr, "R9", "frames after sleep", nfr, fp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual no done expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !done && !err && !in_ready, "R1", "pins in reset",
        {cs_n, sck, done, err, in_ready}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !sck && !done && !err && !in_ready, "R1", "pins after reset",
        {cs_n, sck, done, err, in_ready}, 5'b10000);
    run_case('h0100F0, 40, 0, 1, 0, 5, 200, 0);   // page split, 4 KB
    run_case('h007FF0, 64, 1, 2, 1, 8, 200, 0);   // two 32 KB blocks, busy flicker (R8)
    run_case('h0300FF, 300, 2, 0, 0, 0, 200, 0);  // 64 KB, bursts 1/256/43
    run_case('h000000, 20, 3, 3, 1, 4, 200, 0);   // whole chip (R4)
    run_case('h020000, 0, 0, 0, 0, 2, 200, 0);    // R13 aligned empty
    run_case('h020010, 0, 0, 0, 0, 2, 200, 0);    // R5 unaligned empty: one block
    run_case('h001000, 10, 0, 1000, 0, 2, 5, 1);  // R12 timeout
    for (int i = 0; i < 5; i++)
      run_case(int'($urandom % 'hFE0000), int'($urandom % 180), int'($urandom % 4),
               int'($urandom % 4), bit'($urandom % 2), int'($urandom % 12), 200, 0);
    chk(mode_bad == 0, "R10", "mode 0 violations", mode_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule